// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Aggregator

This block keeps the interrupt-pending state of a two-channel IDE host controller inside configuration-space registers and drives a single level-sensitive PCI interrupt line. Each channel's pending flag can be seen in two places: a legacy status byte (one per channel) and a shared unified status byte. Software may clear the flag through either location. The block then copies the result to the other location, so both always agree.

Drive-side logic gives one interrupt level per channel. A rising level latches that channel's pending flag and a falling level drops it. A 32-bit configuration port with a dword address and byte-lane enables reads and writes the registers. A narrow side port, used by the bus-master register space, sets the per-channel block (mask) bits. The output line is high while some channel is pending and not blocked.

Top module: `ide_irq_agg`

## Requirements
- R1: After reset, all pending and block bits read 0 and `irq_o` is 0. The channel-enable byte at byte offset 0x51 reads 0x04, or 0x0C when parameter `SECONDARY_EN` is 1.
- R2: Byte 0x09 always reads 0x8F and byte 0x3D always reads 0x01.
- R3: A rising edge on `ch_level_i[0]` sets channel 0 pending at both 0x50 bit 2 and 0x71 bit 2. A rising edge on `ch_level_i[1]` sets channel 1 pending at both 0x57 bit 4 and 0x71 bit 3. A level that stays high does not set the flag again.
- R4: A falling edge on a channel's level clears that channel's pending flag in both locations.
- R5: A configuration write with a 1 in 0x50 bit 2 or 0x57 bit 4 clears that channel's pending flag in both locations. Writing 0 to those bits leaves the flag unchanged.
- R6: A configuration write with a 1 in 0x71 bit 2 or bit 3 clears channel 0 or channel 1 pending, respectively, in both locations.
- R7: Bits of bytes 0x50, 0x57 and 0x71 other than the pending bits are never set by a configuration write.
- R8: Block bits (0x71 bit 4 for channel 0, bit 5 for channel 1) change only on a side-port write, which loads them from `dma_mode_wdata_i[5:4]`.
- R9: `irq_o` equals (pending0 AND NOT block0) OR (pending1 AND NOT block1), taken from the register state one clock earlier.
- R10: If a rising level and a clearing write hit the same channel in the same cycle, the flag ends up set.
- R11: The channel-enable byte 0x51 is written only when byte lane 1 of dword 0x14 is enabled. A write whose lane enable for a byte is 0 leaves that byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_level_i | input | 2 | Per-channel interrupt level from the drive side |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be_i | input | 4 | Byte-lane enables for the write |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for `cfg_addr_i`, combinational |
| dma_mode_wr_i | input | 1 | Side-port write strobe for the block bits |
| dma_mode_wdata_i | input | 8 | Side-port data; bits 5:4 are the block bits |
| irq_o | output | 1 | Combined level-sensitive interrupt, registered |

## Verification
If the two copies of a pending flag disagree, reading the legacy byte and the unified byte in the same cycle shows the mismatch. That happens in the cycle right after the write or level edge that caused it. A wrong pending or block bit shows on `irq_o` one clock later, because the line is re-registered from the state on every cycle. A reference model in the bench, compared on every clock, therefore catches a bad state within two cycles. Lost or spurious edge detection shows up as a flag that stays set, or comes back, while the level is held.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
    localparam int NCH      = 2;
    localparam int CFG_AW   = 6;
    localparam int CFG_DW   = 32;
    localparam int CFG_BE_W = CFG_DW / 8;

    // dword indices of the registers
    localparam logic [CFG_AW-1:0] DW_PROGIF = 6'h02; // byte 0x09 in lane 1
    localparam logic [CFG_AW-1:0] DW_INTPIN = 6'h0F; // byte 0x3D in lane 1
    localparam logic [CFG_AW-1:0] DW_LEG0   = 6'h14; // 0x50 lane0, 0x51 lane1
    localparam logic [CFG_AW-1:0] DW_LEG1   = 6'h15; // 0x57 lane3
    localparam logic [CFG_AW-1:0] DW_UNI    = 6'h1C; // 0x71 lane1

    // bit positions inside the 32-bit word
    localparam int BIT_LEG0   = 2;        // 0x50 bit 2
    localparam int BIT_LEG1   = 24 + 4;   // 0x57 bit 4
    localparam int BIT_UNI_P0 = 8 + 2;    // 0x71 bit 2
    localparam int BIT_UNI_P1 = 8 + 3;    // 0x71 bit 3

    localparam logic [7:0] PROGIF_VAL = 8'h8F;
    localparam logic [7:0] INTPIN_VAL = 8'h01;

    typedef struct packed {
        logic [NCH-1:0] leg;   // legacy copies
        logic [NCH-1:0] pend;  // unified copies
        logic [NCH-1:0] blk;   // block mask
        logic [7:0]     en;    // channel enable byte
    } irq_state_t;
endpackage

// File: rtl/ide_irq_edge.sv
module ide_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = level_i;
        rise_o = level_i & ~lvl_q;
        fall_o = ~level_i & lvl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
    import ide_irq_pkg::*;
#(
    parameter bit SECONDARY_EN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [CFG_AW-1:0]   addr_i,
    input  logic [CFG_BE_W-1:0] be_i,
    input  logic [CFG_DW-1:0]   wdata_i,
    input  logic                blk_wr_i,
    input  logic [NCH-1:0]      blk_wdata_i,
    input  logic [NCH-1:0]      rise_i,
    input  logic [NCH-1:0]      fall_i,
    output irq_state_t          state_o
);
    localparam logic [7:0] EN_RESET = {4'b0000, SECONDARY_EN, 1'b1, 2'b00};

    irq_state_t s_d, s_q;
    logic leg0_hit, leg1_hit, uni_hit, en_hit;
    logic wdata_unused;

    assign wdata_unused = ^wdata_i;

    always_comb begin
        leg0_hit = wr_i && (addr_i == DW_LEG0) && be_i[0];
        leg1_hit = wr_i && (addr_i == DW_LEG1) && be_i[3];
        uni_hit  = wr_i && (addr_i == DW_UNI)  && be_i[1];
        en_hit   = wr_i && (addr_i == DW_LEG0) && be_i[1];

        s_d = s_q;
        // write-one-to-clear on each side
        if (leg0_hit && wdata_i[BIT_LEG0])   s_d.leg[0]  = 1'b0;
        if (leg1_hit && wdata_i[BIT_LEG1])   s_d.leg[1]  = 1'b0;
        if (uni_hit  && wdata_i[BIT_UNI_P0]) s_d.pend[0] = 1'b0;
        if (uni_hit  && wdata_i[BIT_UNI_P1]) s_d.pend[1] = 1'b0;
        // resynchronise the copy that was not written
        if (leg0_hit || leg1_hit) s_d.pend = s_d.leg;
        if (uni_hit)              s_d.leg  = s_d.pend;
        if (en_hit)   s_d.en  = wdata_i[15:8];
        if (blk_wr_i) s_d.blk = blk_wdata_i;
        // level events: applied last, so a rising level beats a clear
        for (int c = 0; c < NCH; c++) begin
            if (fall_i[c]) begin
                s_d.leg[c]  = 1'b0;
                s_d.pend[c] = 1'b0;
            end
            if (rise_i[c]) begin
                s_d.leg[c]  = 1'b1;
                s_d.pend[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.leg  <= '0;
            s_q.pend <= '0;
            s_q.blk  <= '0;
            s_q.en   <= EN_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q;

    // R3 / R5 / R6: both copies agree after every update
    a_r3_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.leg == s_q.pend);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R10: a rising level leaves the flag set regardless of any clear
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            rise_i[c] |=> s_q.pend[c]);
        // R4: a falling level clears the flag
        a_r4_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
            fall_i[c] |=> !s_q.pend[c]);
    end

    // R8: block bits move only on a side-port write
    a_r8_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_wr_i |=> $stable(s_q.blk));
    // R11: enable byte moves only when its lane is written
    a_r11_en_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !en_hit |=> $stable(s_q.en));
endmodule

// File: rtl/ide_irq_out.sv
module ide_irq_out
    import ide_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_i,
    input  logic [NCH-1:0] blk_i,
    output logic           irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(pend_i & ~blk_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R9: fully blocked channels never raise the line
    a_r9_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&blk_i) |=> !irq_o);
    // R9: nothing pending means the line is low next cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);
endmodule

// File: rtl/ide_irq_agg.sv
module ide_irq_agg
    import ide_irq_pkg::*;
#(
    parameter bit SECONDARY_EN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ch_level_i,
    input  logic                cfg_wr_i,
    input  logic [CFG_AW-1:0]   cfg_addr_i,
    input  logic [CFG_BE_W-1:0] cfg_be_i,
    input  logic [CFG_DW-1:0]   cfg_wdata_i,
    output logic [CFG_DW-1:0]   cfg_rdata_o,
    input  logic                dma_mode_wr_i,
    input  logic [7:0]          dma_mode_wdata_i,
    output logic                irq_o
);
    logic [NCH-1:0] rise, fall;
    irq_state_t     st;
    logic           dma_unused;

    assign dma_unused = ^{dma_mode_wdata_i[7:6], dma_mode_wdata_i[3:0]};

    for (genvar c = 0; c < NCH; c++) begin : g_edge
        ide_irq_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (ch_level_i[c]),
            .rise_o  (rise[c]),
            .fall_o  (fall[c])
        );
    end

    ide_irq_regs #(.SECONDARY_EN(SECONDARY_EN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cfg_wr_i),
        .addr_i      (cfg_addr_i),
        .be_i        (cfg_be_i),
        .wdata_i     (cfg_wdata_i),
        .blk_wr_i    (dma_mode_wr_i),
        .blk_wdata_i (dma_mode_wdata_i[5:4]),
        .rise_i      (rise),
        .fall_i      (fall),
        .state_o     (st)
    );

    ide_irq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (st.pend),
        .blk_i  (st.blk),
        .irq_o  (irq_o)
    );

    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_addr_i)
            DW_PROGIF: cfg_rdata_o[15:8] = PROGIF_VAL;
            DW_INTPIN: cfg_rdata_o[15:8] = INTPIN_VAL;
            DW_LEG0: begin
                cfg_rdata_o[BIT_LEG0] = st.leg[0];
                cfg_rdata_o[15:8]     = st.en;
            end
            DW_LEG1: cfg_rdata_o[BIT_LEG1] = st.leg[1];
            DW_UNI: begin
                cfg_rdata_o[BIT_UNI_P0] = st.pend[0];
                cfg_rdata_o[BIT_UNI_P1] = st.pend[1];
                cfg_rdata_o[13:12]      = st.blk;
            end
            default: cfg_rdata_o = '0;
        endcase
    end
endmodule

// File: tb/ide_irq_agg_tb.sv
module ide_irq_agg_tb;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ch_level = 2'b00;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = 6'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        dma_wr = 1'b0;
    logic [7:0]  dma_wdata = 8'h00;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .ch_level_i(ch_level),
        .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .dma_mode_wr_i(dma_wr), .dma_mode_wdata_i(dma_wdata), .irq_o(irq)
    );

    // behavioural reference: one pending flag per channel, edge history, mask
    bit [1:0] m_p, m_b, m_lvl;
    bit [7:0] m_en;
    bit       m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p = 0; m_b = 0; m_lvl = 0; m_en = 8'h04; m_irq = 0;
        end else begin
            m_irq = (m_p[0] && !m_b[0]) || (m_p[1] && !m_b[1]);
            if (cfg_wr && cfg_addr == 6'h14 && cfg_be[0] && cfg_wdata[2])  m_p[0] = 0;
            if (cfg_wr && cfg_addr == 6'h15 && cfg_be[3] && cfg_wdata[28]) m_p[1] = 0;
            if (cfg_wr && cfg_addr == 6'h1C && cfg_be[1]) begin
                if (cfg_wdata[10]) m_p[0] = 0;
                if (cfg_wdata[11]) m_p[1] = 0;
            end
            if (cfg_wr && cfg_addr == 6'h14 && cfg_be[1]) m_en = cfg_wdata[15:8];
            if (dma_wr) m_b = dma_wdata[5:4];
            for (int c = 0; c < 2; c++) begin
                if (ch_level[c] && !m_lvl[c]) m_p[c] = 1;
                if (!ch_level[c] && m_lvl[c]) m_p[c] = 0;
            end
            m_lvl = ch_level;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        logic [31:0] v = 32'h0;
        case (a)
            6'h02: v[15:8] = 8'h8F;
            6'h0F: v[15:8] = 8'h01;
            6'h14: begin v[2] = m_p[0]; v[15:8] = m_en; end
            6'h15: v[28] = m_p[1];
            6'h1C: begin v[10] = m_p[0]; v[11] = m_p[1]; v[13:12] = m_b; end
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the interrupt line (R9)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R9 irq per cycle", {31'b0, irq}, {31'b0, m_irq});
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        tick(1);
        cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    endtask

    task automatic dma_write(input logic [7:0] d);
        dma_wr = 1'b1; dma_wdata = d;
        tick(1);
        dma_wr = 1'b0; dma_wdata = 8'h00;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
        chk({tag, " model"}, cfg_rdata, exp_rd(a));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd("R1 legacy0/enable", 6'h14, 32'h0000_0400);
        rd("R1 legacy1", 6'h15, 32'h0);
        rd("R1 unified", 6'h1C, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        // R2 fixed bytes
        rd("R2 prog-if", 6'h02, 32'h0000_8F00);
        rd("R2 int pin", 6'h0F, 32'h0000_0100);

        // R3 channel 0 rise sets both copies; irq next cycle (R9)
        ch_level[0] = 1'b1; tick(1);
        rd("R3 ch0 legacy", 6'h14, 32'h0000_0404);
        rd("R3 ch0 unified", 6'h1C, 32'h0000_0400);
        tick(1);
        chk("R9 irq after ch0", {31'b0, irq}, 32'h1);

        // R5 legacy W1C: zero has no effect, one clears both
        cfg_write(6'h14, 4'b0001, 32'h0);
        rd("R5 zero write keeps", 6'h1C, 32'h0000_0400);
        cfg_write(6'h14, 4'b0001, 32'h0000_0004);
        rd("R5 legacy clear unified", 6'h1C, 32'h0);
        rd("R5 legacy clear legacy", 6'h14, 32'h0000_0400);
        // R3 held level does not set again
        tick(2);
        rd("R3 held level no reset", 6'h1C, 32'h0);

        // R3 channel 1, R6 unified W1C
        ch_level[1] = 1'b1; tick(1);
        rd("R3 ch1 legacy", 6'h15, 32'h1000_0000);
        rd("R3 ch1 unified", 6'h1C, 32'h0000_0800);
        cfg_write(6'h1C, 4'b0010, 32'h0000_0800);
        rd("R6 unified clear legacy", 6'h15, 32'h0);
        rd("R6 unified clear unified", 6'h1C, 32'h0);

        // R4 falling edge clears
        ch_level = 2'b00; tick(1);
        ch_level[0] = 1'b1; tick(1);
        rd("R4 pre-fall set", 6'h14, 32'h0000_0404);
        ch_level[0] = 1'b0; tick(1);
        rd("R4 fall legacy", 6'h14, 32'h0000_0400);
        rd("R4 fall unified", 6'h1C, 32'h0);

        // R7 / R8 all-ones writes leave other bits and block bits clear
        cfg_write(6'h15, 4'b1000, 32'hFFFF_FFFF);
        cfg_write(6'h1C, 4'b0010, 32'hFFFF_FFFF);
        rd("R7 legacy1 other bits", 6'h15, 32'h0);
        rd("R7 R8 unified other bits", 6'h1C, 32'h0);
        cfg_write(6'h14, 4'b0001, 32'h0000_00FF);
        rd("R7 legacy0 other bits", 6'h14, 32'h0000_0400);

        // R8 side-port block, R9 masking
        dma_write(8'h10);
        rd("R8 block ch0", 6'h1C, 32'h0000_1000);
        ch_level[0] = 1'b1; tick(2);
        chk("R9 blocked ch0", {31'b0, irq}, 32'h0);
        dma_write(8'hCF); // bits 5:4 = 00
        rd("R8 unblock", 6'h1C, 32'h0000_0400);
        tick(1);
        chk("R9 unblocked ch0", {31'b0, irq}, 32'h1);
        dma_write(8'h30);
        tick(1);
        chk("R9 both blocked", {31'b0, irq}, 32'h0);
        dma_write(8'h00);
        ch_level[0] = 1'b0; tick(2);

        // R10 same-cycle rise and clear on channel 1
        ch_level[1] = 1'b0; tick(1);
        ch_level[1] = 1'b1;
        cfg_write(6'h1C, 4'b0010, 32'h0000_0800);
        rd("R10 set wins unified", 6'h1C, 32'h0000_0800);
        rd("R10 set wins legacy", 6'h15, 32'h1000_0000);
        ch_level[1] = 1'b0; tick(1);
        ch_level[0] = 1'b1; tick(1);
        ch_level[0] = 1'b1;
        cfg_write(6'h14, 4'b0001, 32'h0000_0004);
        ch_level[0] = 1'b0; tick(1);
        ch_level[0] = 1'b1;
        cfg_write(6'h14, 4'b0001, 32'h0000_0004);
        rd("R10 set wins ch0", 6'h1C, 32'h0000_0400);

        // R11 enable byte lane
        cfg_write(6'h14, 4'b0010, 32'h0000_AB00);
        rd("R11 enable written", 6'h14, 32'h0000_AB04);
        cfg_write(6'h14, 4'b0101, 32'hFFFF_FF00);
        rd("R11 lane off keeps", 6'h14, 32'h0000_AB04);

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule